// File: doc/BRIEF.md
# Repetitive trigger generator

This block produces two independent streams of single-cycle pulses from one free-running system clock: a trigger stream and a front-end reset stream. Each stream has its own 5-bit rate code and its own enable. The code is read as two fields. The upper two bits choose a decade, and each step of that field slows the rate by a factor of ten. The lower three bits choose one of eight rows. The row order is not monotonic: row 1 sits one decade below the pattern the other rows follow.

The front-end reset stream uses the same row and decade structure as the trigger stream, shifted four decades slower. A randomize input turns the trigger stream into a thinned version of itself. A pseudo-random sequence decides, at each fixed-period expiry, whether that pulse is let through, so the mean rate becomes one quarter of the selected rate. The clock frequency is the parameter `CLK_HZ` (default 40 MHz). Periods are that frequency divided by the chosen rate, rounded to the nearest cycle, with a minimum of one cycle.

Top module: `rep_trig_gen`

## Requirements
- R1: While rst_ni is low, both trig_o and fe_rst_o are 0.
- R2: With trig_code_i[4:3]=0, the rows trig_code_i[2:0]=0..7 give trigger rates of 600, 60, 300, 200, 150, 120, 100 and 50 kHz. The period P is CLK_HZ/rate rounded to the nearest cycle, with a minimum of 1.
- R3: Each increment of trig_code_i[4:3] divides the trigger rate by 10. For example, code 10 gives 30 kHz, code 19 gives 2 kHz and code 29 gives 120 Hz.
- R4: fe_rst_code_i uses the same field layout. With fe_rst_code_i[4:3]=0, rows 0..7 give 60, 6, 30, 20, 15, 12, 10 and 5 Hz. The slowest code, 31, gives 0.005 Hz.
- R5: A configuration with the trigger code in bits 4-0 and the reset code in bits 12-8 of the value 0x0E06 gives trigger code 6 and reset code 14. These produce 100 kHz triggers and 1 Hz front-end resets.
- R6: Each output pulses only while its own enable is 1, and it is 0 from the first clock edge at which the enable is sampled low. The counter clears while the stream is disabled. When the enable rises with a stable code, the first pulse follows exactly P clock edges later, and pulses then repeat every P edges.
- R7: Every period expiry produces exactly one pulse of one cycle. When P=1 the output is high on every cycle.
- R8: A change of rate code while enabled restarts the period count. The first pulse at the new rate comes P+1 edges after the new code is applied, and no partial period is emitted.
- R9: With rand_en_i=1, trigger pulses occur only at positions of the fixed-period grid. The pulse at each grid point is passed when two chosen bits of a 16-bit maximal-length LFSR are both 1, so the mean rate is one quarter of the fixed rate.
- R10: rand_en_i has no effect on fe_rst_o. With trig_en_i=0, rand_en_i produces no trigger pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_code_i | input | 5 | Trigger rate code: [4:3] decade, [2:0] row |
| fe_rst_code_i | input | 5 | Front-end reset rate code, same layout |
| trig_en_i | input | 1 | Trigger stream enable |
| fe_rst_en_i | input | 1 | Front-end reset stream enable |
| rand_en_i | input | 1 | Random thinning of the trigger stream |
| trig_o | output | 1 | Trigger pulse, one cycle |
| fe_rst_o | output | 1 | Front-end reset pulse, one cycle |

## Verification
A wrong lookup entry or a bad decade shift shows up as a pulse interval different from the one the requirement predicts. This appears at the second pulse after arming, which is within two periods. A counter that is not cleared on a code change or on disable shifts the first pulse away from P or P+1 edges, and with a large old count it can suppress pulses for a very long wrap. Both faults are visible within one new period. A stuck or degenerate random sequence shows up either as a pulse count over a thousand grid points that lies far from one quarter, or as a pulse that falls off the fixed grid.

// File: rtl/rep_trig_pkg.sv
package rep_trig_pkg;
  localparam int CODE_W       = 5;
  localparam int ROW_W        = 3;
  localparam int NUM_CODES    = 1 << CODE_W;
  localparam int FE_DEC_SHIFT = 4;   // reset stream sits 10^4 below trigger
  localparam int LFSR_W       = 16;

  // row rates of the fastest trigger decade, Hz (row 1 breaks the pattern)
  function automatic longint unsigned row_rate_hz(input int row);
    case (row)
      0:       return 64'd600_000;
      1:       return 64'd60_000;
      2:       return 64'd300_000;
      3:       return 64'd200_000;
      4:       return 64'd150_000;
      5:       return 64'd120_000;
      6:       return 64'd100_000;
      default: return 64'd50_000;
    endcase
  endfunction

  function automatic longint unsigned pow10(input int e);
    longint unsigned v = 64'd1;
    for (int i = 0; i < e; i++) v = v * 64'd10;
    return v;
  endfunction

  // nearest-cycle period, at least one cycle
  function automatic longint unsigned period_cycles(input longint unsigned clk_hz,
                                                    input int code, input int extra_dec);
    longint unsigned r = row_rate_hz(code % (1 << ROW_W));
    longint unsigned n = clk_hz * pow10((code >> ROW_W) + extra_dec);
    longint unsigned p = (n + r / 2) / r;
    return (p == 0) ? 64'd1 : p;
  endfunction
endpackage

// File: rtl/rtg_rate_lut.sv
module rtg_rate_lut
  import rep_trig_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 40_000_000,
  parameter int EXTRA_DEC = 0,
  parameter int CNT_W = 34
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  period_o
);
  logic [CNT_W-1:0] tbl [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_ent
    localparam longint unsigned P = period_cycles(CLK_HZ, g, EXTRA_DEC);
    assign tbl[g] = CNT_W'(P);
  end

  assign period_o = tbl[code_i];
endmodule

// File: rtl/rtg_period_timer.sv
module rtg_period_timer #(
  parameter int CNT_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i || restart_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= period_i - CNT_W'(1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtg_lfsr_gate.sv
module rtg_lfsr_gate
  import rep_trig_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,  // x^16+x^14+x^13+x^11+1
  parameter int BIT_A = 3,
  parameter int BIT_B = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic rand_en_i,
  output logic pass_o
);
  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lfsr_q <= SEED;
    else if (adv_i) lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
  end

  // both bits set: one grid point in four on average
  assign pass_o = !rand_en_i || (lfsr_q[BIT_A] && lfsr_q[BIT_B]);
endmodule

// File: rtl/rep_trig_gen.sv
module rep_trig_gen
  import rep_trig_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 40_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] trig_code_i,
  input  logic [CODE_W-1:0] fe_rst_code_i,
  input  logic              trig_en_i,
  input  logic              fe_rst_en_i,
  input  logic              rand_en_i,
  output logic              trig_o,
  output logic              fe_rst_o
);
  localparam int NUM_CH = 2;
  localparam int CNT_W  = $clog2(period_cycles(CLK_HZ, NUM_CODES - 1, FE_DEC_SHIFT) + 1);

  logic [NUM_CH-1:0][CODE_W-1:0] code, code_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  period;
  logic [NUM_CH-1:0]             en, tick;
  logic                          pass;

  assign code = {fe_rst_code_i, trig_code_i};
  assign en   = {fe_rst_en_i, trig_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rtg_rate_lut #(
      .CLK_HZ   (CLK_HZ),
      .EXTRA_DEC(c * FE_DEC_SHIFT),
      .CNT_W    (CNT_W)
    ) u_lut (
      .code_i  (code[c]),
      .period_o(period[c])
    );

    rtg_period_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en[c]),
      .restart_i(code[c] != code_q[c]),
      .period_i (period[c]),
      .tick_o   (tick[c])
    );
  end

  rtg_lfsr_gate u_rand (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (tick[0]),
    .rand_en_i(rand_en_i),
    .pass_o   (pass)
  );

  assign trig_o   = tick[0] && pass;
  assign fe_rst_o = tick[1];
endmodule

// File: rtl/rep_trig_gen_chk.sv
module rep_trig_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       trig_en_i,
  input logic       fe_rst_en_i,
  input logic       trig_o,
  input logic       fe_rst_o,
  input logic [1:0] p_is_one,
  input logic [1:0] code_chg
);
  // R6
  trig_en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_en_i |=> !trig_o);
  // R6
  fe_en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fe_rst_en_i |=> !fe_rst_o);
  // R7
  trig_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && !p_is_one[0]) |=> !trig_o);
  // R7
  fe_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_rst_o && !p_is_one[1]) |=> !fe_rst_o);
  // R8
  trig_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_en_i && code_chg[0]) |=> !trig_o);
  // R8
  fe_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_rst_en_i && code_chg[1]) |=> !fe_rst_o);
endmodule

bind rep_trig_gen rep_trig_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_en_i  (trig_en_i),
  .fe_rst_en_i(fe_rst_en_i),
  .trig_o     (trig_o),
  .fe_rst_o   (fe_rst_o),
  .p_is_one   ({period[1] == CNT_W'(1), period[0] == CNT_W'(1)}),
  .code_chg   ({fe_rst_code_i != code_q[1], trig_code_i != code_q[0]})
);

// File: tb/tb_rep_trig_gen.sv
module tb_rep_trig_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4:0] tcode = '0, fcode = '0;
  logic ten = 1'b0, fen = 1'b0, ren = 1'b0;
  logic trig_f, fe_f, trig_s, fe_s;
  int checks = 0, failures = 0;

  // fast clock model for trigger rates, slow one for reset rates
  rep_trig_gen #(.CLK_HZ(1_200_000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_code_i(tcode), .fe_rst_code_i(fcode),
    .trig_en_i(ten), .fe_rst_en_i(fen), .rand_en_i(ren),
    .trig_o(trig_f), .fe_rst_o(fe_f));

  rep_trig_gen #(.CLK_HZ(120)) dut_slow (
    .clk_i(clk), .rst_ni(rst_n), .trig_code_i(tcode), .fe_rst_code_i(fcode),
    .trig_en_i(ten), .fe_rst_en_i(fen), .rand_en_i(ren),
    .trig_o(trig_s), .fe_rst_o(fe_s));

  function automatic logic probe(input int sel);
    case (sel)
      0: return trig_f;
      1: return fe_f;
      2: return trig_s;
      default: return fe_s;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic arm(input logic [4:0] tc, input logic [4:0] fc, input logic te, input logic fe);
    @(negedge clk);
    ten = 1'b0; fen = 1'b0; tcode = tc; fcode = fc;
    repeat (2) @(negedge clk);
    ten = te; fen = fe;
  endtask

  task automatic meas(input int sel, input int limit, output int first, output int gap);
    int n, last;
    n = 0; last = 0; first = -1; gap = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (probe(sel)) begin
        if (n == 0) first = k; else gap = k - last;
        last = k;
        n++;
        if (n == 2) break;
      end
    end
  endtask

  task automatic count_pulses(input int sel, input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (probe(sel)) n++;
    end
  endtask

  task automatic t_reset;
    int hits = 0;
    ten = 1'b1; fen = 1'b1; tcode = 5'd0; fcode = 5'd0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (trig_f || fe_f || trig_s || fe_s) hits++;
    end
    chk("R1", "pulses during reset", hits, 0);
    ten = 1'b0; fen = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_disabled;
    int n = 0, m;
    arm(5'd0, 5'd0, 1'b0, 1'b0);
    for (int s = 0; s < 4; s++) begin
      count_pulses(s, 30, m);
      n += m;
    end
    chk("R6", "pulses with enables low", n, 0);
  endtask

  task automatic t_rows;
    int per [8] = '{2, 20, 4, 6, 8, 10, 12, 24};
    int f, g;
    for (int r = 0; r < 8; r++) begin
      arm(5'(r), 5'd0, 1'b1, 1'b0);
      meas(0, 3 * per[r], f, g);
      chk("R2", $sformatf("row %0d first pulse", r), f, per[r]);
      chk("R2", $sformatf("row %0d interval", r), g, per[r]);
    end
  endtask

  task automatic t_decade;
    int cd [3] = '{10, 19, 29};
    int pr [3] = '{40, 600, 10000};
    int f, g;
    for (int i = 0; i < 3; i++) begin
      arm(5'(cd[i]), 5'd0, 1'b1, 1'b0);
      meas(0, 3 * pr[i], f, g);
      chk("R3", $sformatf("code %0d interval", cd[i]), g, pr[i]);
    end
  endtask

  task automatic t_fe_rows;
    int cd [5] = '{0, 1, 4, 7, 31};
    int pr [5] = '{2, 20, 8, 24, 24000};
    int f, g;
    for (int i = 0; i < 5; i++) begin
      arm(5'd0, 5'(cd[i]), 1'b0, 1'b1);
      meas(3, 3 * pr[i], f, g);
      chk("R4", $sformatf("reset code %0d first", cd[i]), f, pr[i]);
      chk("R4", $sformatf("reset code %0d interval", cd[i]), g, pr[i]);
    end
  endtask

  task automatic t_combined;
    logic [15:0] word = 16'h0E06;
    int f, g;
    arm(word[4:0], word[12:8], 1'b1, 1'b1);
    meas(0, 60, f, g);
    chk("R5", "100 kHz trigger interval", g, 12);
    meas(3, 400, f, g);
    chk("R5", "1 Hz reset interval", g, 120);
  endtask

  task automatic t_width;
    int n, adj = 0;
    logic prev = 1'b0;
    arm(5'd0, 5'd0, 1'b1, 1'b0);
    count_pulses(2, 20, n);
    chk("R7", "P=1 pulses in 20 cycles", n, 20);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (trig_f) n++;
      if (trig_f && prev) adj++;
      prev = trig_f;
    end
    chk("R7", "P=2 pulses in 20 cycles", n, 10);
    chk("R7", "back-to-back pulses at P=2", adj, 0);
  endtask

  task automatic t_restart;
    int f, g, n;
    arm(5'd19, 5'd0, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    tcode = 5'd2;
    meas(0, 60, f, g);
    chk("R8", "first pulse after code change", f, 5);
    chk("R8", "interval after code change", g, 4);
    @(negedge clk);
    ten = 1'b0;
    count_pulses(0, 20, n);
    chk("R6", "pulses after disable", n, 0);
  endtask

  task automatic t_random;
    int n = 0, off = 0, f, g;
    arm(5'd0, 5'd0, 1'b1, 1'b0);
    ren = 1'b1;
    for (int k = 1; k <= 2000; k++) begin
      @(negedge clk);
      if (trig_f) begin
        n++;
        if (k % 2 != 0) off++;
      end
    end
    chk("R9", "random pulses off the fixed grid", off, 0);
    chk("R9", "random count within 180..320 of 1000 ticks", (n >= 180 && n <= 320), 1);
    arm(5'd0, 5'd14, 1'b0, 1'b1);
    count_pulses(0, 100, n);
    chk("R10", "random pulses with trigger disabled", n, 0);
    meas(3, 400, f, g);
    chk("R10", "reset interval with randomizer on", g, 120);
    ren = 1'b0;
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_rows();
    t_decade();
    t_fe_rows();
    t_combined();
    t_width();
    t_restart();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule